// File: doc/BRIEF.md
# Two-Cluster Split-Address Data Cache Router

This block sits between two processor clusters and two data cache modules, with one module attached to each cluster. The logical address space is split into two halves. Each half has its own stack, heap and global data, and each half is served by one module. Every load or store a cluster issues is steered by its address. An access to the cluster's own module goes straight there and returns after that module's fixed latency, with no stall.

An access that belongs to the other cluster's module is still legal and still returns correct data, but it costs time. The block freezes both clusters and waits until the inter-cluster bus has nothing left in flight. It then sends the request across, waits for the module's answer, and hands the data back to the requester. For a store, the answer is an acknowledge, and the stall lifts in the same cycle. Only one such crossing is in progress at a time.

A build may populate only one module. In that case every access goes to that module whatever its address, and the cluster without a module always takes the crossing path. The module contents are modelled inside the block as small storage arrays behind a fixed-latency pipeline.

Top module: `dcache_xroute`

## Requirements
- R1: The most significant address bit selects the owning module: 0 selects module 0, which sits beside cluster 0, and 1 selects module 1, which sits beside cluster 1. The low log2(DEPTH) address bits select the word inside the module. The two spaces hold separate data for the same word index.
- R2: A request is accepted in a cycle where req_valid is high and stall is low. An accepted request to the cluster's own module raises rsp_valid exactly LATn cycles later, where n is the module number. The cluster's stall stays low throughout.
- R3: A store writes the module word in its acceptance cycle. Its response has rsp_ack=1 and rsp_data=0. A load response has rsp_ack=0 and carries the stored word.
- R4: A load to the other cluster's module, accepted while the bus is empty, answers LATm+3 cycles after acceptance, where m is the owning module. Both stall bits are high for the LATm+2 cycles in between and low in the answer cycle.
- R5: The crossing request is not sent to the module while xbus_inflight is nonzero. Each extra cycle spent waiting for zero delays the answer and the both-cluster stall by one cycle.
- R6: A store to the other cluster's module returns rsp_ack=1 after the same crossing sequence. The stall drops in the cycle of that acknowledge, and a later local load by the owning cluster reads the stored word.
- R7: While a crossing is in progress, any new request from either cluster sees stall high and is held. This includes the answer cycle, for a new crossing request.
- R8: If both clusters raise crossing requests in the same idle cycle, cluster 1 is accepted and cluster 0 sees stall high. Cluster 0 is accepted in the first idle cycle after cluster 1's answer.
- R9: With only module 0 populated (POP_MASK=2'b01), every access goes to module 0 whatever its top address bit. Cluster 0 is always local with latency LAT0, and cluster 1 always crosses with latency LAT0+3.
- R10: After reset, stall and rsp_valid are low and every module word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, one bit per cluster |
| req_we | input | 2 | 1 = store, 0 = load, per cluster |
| req_addr | input | 2 x ADDR_W | Request address per cluster |
| req_wdata | input | 2 x DATA_W | Store data per cluster |
| xbus_inflight | input | CNT_W | Transfers still in flight on the inter-cluster bus |
| stall | output | 2 | Cluster must hold its request and stay frozen |
| rsp_valid | output | 2 | Response valid per cluster |
| rsp_ack | output | 2 | Response is a store acknowledge |
| rsp_data | output | 2 x DATA_W | Load data per cluster |

## Verification
The bench builds two copies of the block. The first populates both modules with unequal latencies (LAT0=2, LAT1=4). This makes local, crossing, drained and simultaneous-crossing timings differ per direction, so the wrong module or the wrong latency shows up in the measured cycle counts. The second populates only module 0 with LAT0=3. This brings the single-module routing within reach, where cluster 1 has no module of its own and every one of its accesses must cross.

// File: rtl/dxr_pkg.sv
package dxr_pkg;
   localparam int NCL = 2;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_DRAIN,
      RS_SEND,
      RS_WAIT,
      RS_REPLY
   } rs_state_e;
endpackage

// File: rtl/dxr_bank.sv
module dxr_bank #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int LAT    = 2,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_we,
   input  logic              in_remote,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [DATA_W-1:0] in_wdata,
   output logic              out_valid,
   output logic              out_we,
   output logic              out_remote,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (LAT < 1) begin : g_bad_lat
         $error("dxr_bank: LAT must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("dxr_bank: DEPTH must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [LAT-1:0]    v_q, we_q, rm_q;
   logic [DATA_W-1:0] d_q [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (in_valid && in_we) begin
         mem[in_idx] <= in_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q[0]  <= 1'b0;
         we_q[0] <= 1'b0;
         rm_q[0] <= 1'b0;
         d_q[0]  <= '0;
      end else begin
         v_q[0]  <= in_valid;
         we_q[0] <= in_we;
         rm_q[0] <= in_remote;
         d_q[0]  <= in_we ? '0 : mem[in_idx];
      end
   end

   generate
      for (genvar g = 1; g < LAT; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q[g]  <= 1'b0;
               we_q[g] <= 1'b0;
               rm_q[g] <= 1'b0;
               d_q[g]  <= '0;
            end else begin
               v_q[g]  <= v_q[g-1];
               we_q[g] <= we_q[g-1];
               rm_q[g] <= rm_q[g-1];
               d_q[g]  <= d_q[g-1];
            end
         end
      end
   endgenerate

   assign out_valid  = v_q[LAT-1];
   assign out_we     = we_q[LAT-1];
   assign out_remote = rm_q[LAT-1];
   assign out_data   = d_q[LAT-1];

   // R3: an accepted store is present in storage on the next cycle
   assert_store_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_we) |=> (mem[$past(in_idx)] == $past(in_wdata)));
endmodule

// File: rtl/dxr_home_map.sv
module dxr_home_map #(
   parameter logic [1:0] POP_MASK = 2'b11
) (
   input  logic [1:0] addr_msb,
   output logic [1:0] home
);
   generate
      if (POP_MASK == 2'b11) begin : g_split
         assign home = addr_msb;
      end else if (POP_MASK == 2'b01) begin : g_only0
         logic unused_msb;
         assign unused_msb = ^addr_msb;
         assign home = 2'b00;
      end else if (POP_MASK == 2'b10) begin : g_only1
         logic unused_msb;
         assign unused_msb = ^addr_msb;
         assign home = 2'b11;
      end else begin : g_none
         $error("dxr_home_map: at least one module must be populated");
      end
   endgenerate
endmodule

// File: rtl/dxr_remote_ctl.sv
module dxr_remote_ctl
   import dxr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   parameter int CNT_W  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             want,
   input  logic [1:0]             req_we,
   input  logic [1:0]             req_home,
   input  logic [1:0][IDX_W-1:0]  req_idx,
   input  logic [1:0][DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]       xbus_inflight,
   input  logic [1:0]             rrsp_valid,
   input  logic [1:0][DATA_W-1:0] rrsp_data,
   output logic [1:0]             grant,
   output logic                   busy,
   output logic                   send_valid,
   output logic                   send_bank,
   output logic                   send_we,
   output logic [IDX_W-1:0]       send_idx,
   output logic [DATA_W-1:0]      send_wdata,
   output logic                   reply_valid,
   output logic                   reply_cl,
   output logic                   reply_ack,
   output logic [DATA_W-1:0]      reply_data
);
   rs_state_e         state_q;
   logic              cl_q, bank_q, we_q, pick;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] wdata_q, data_q;

   // cluster 1 wins a tie
   assign pick  = want[1];
   assign grant = (state_q == RS_IDLE && |want) ? (2'b01 << pick) : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         cl_q    <= 1'b0;
         bank_q  <= 1'b0;
         we_q    <= 1'b0;
         idx_q   <= '0;
         wdata_q <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            RS_IDLE: if (|want) begin
               cl_q    <= pick;
               bank_q  <= req_home[pick];
               we_q    <= req_we[pick];
               idx_q   <= req_idx[pick];
               wdata_q <= req_wdata[pick];
               state_q <= RS_DRAIN;
            end
            RS_DRAIN: if (xbus_inflight == '0) state_q <= RS_SEND;
            RS_SEND:  state_q <= RS_WAIT;
            RS_WAIT: if (rrsp_valid[bank_q]) begin
               data_q  <= rrsp_data[bank_q];
               state_q <= RS_REPLY;
            end
            RS_REPLY: state_q <= RS_IDLE;
            default:  state_q <= RS_IDLE;
         endcase
      end
   end

   assign busy        = (state_q == RS_DRAIN) || (state_q == RS_SEND) ||
                        (state_q == RS_WAIT);
   assign send_valid  = (state_q == RS_SEND);
   assign send_bank   = bank_q;
   assign send_we     = we_q;
   assign send_idx    = idx_q;
   assign send_wdata  = wdata_q;
   assign reply_valid = (state_q == RS_REPLY);
   assign reply_cl    = cl_q;
   assign reply_ack   = we_q;
   assign reply_data  = data_q;

   // R5: the crossing request leaves only after the bus was seen empty
   assert_send_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RS_SEND) |-> ($past(xbus_inflight) == '0));

   // R6: the freeze ends only together with the answer to the requester
   assert_release_with_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> reply_valid);

   // R8: a tie between crossing requests is awarded to cluster 1
   assert_tie_to_cluster1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RS_IDLE && want == 2'b11) |=> (cl_q == 1'b1));
endmodule

// File: rtl/dcache_xroute.sv
module dcache_xroute
   import dxr_pkg::*;
#(
   parameter int         ADDR_W   = 12,
   parameter int         DATA_W   = 32,
   parameter int         DEPTH    = 16,
   parameter int         LAT0     = 2,
   parameter int         LAT1     = 4,
   parameter int         CNT_W    = 3,
   parameter logic [1:0] POP_MASK = 2'b11,
   localparam int        IDX_W    = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             req_valid,
   input  logic [1:0]             req_we,
   input  logic [1:0][ADDR_W-1:0] req_addr,
   input  logic [1:0][DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]       xbus_inflight,
   output logic [1:0]             stall,
   output logic [1:0]             rsp_valid,
   output logic [1:0]             rsp_ack,
   output logic [1:0][DATA_W-1:0] rsp_data
);
   generate
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("dcache_xroute: ADDR_W must exceed the index width");
      end
      if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("dcache_xroute: DEPTH must be a power of two");
      end
   endgenerate

   logic                   unused_addr_bits;
   logic [1:0]             addr_msb, home, remote, local_go, grant;
   logic [1:0][IDX_W-1:0]  req_idx;
   logic                   busy, send_valid, send_bank, send_we;
   logic [IDX_W-1:0]       send_idx;
   logic [DATA_W-1:0]      send_wdata;
   logic                   reply_valid, reply_cl, reply_ack;
   logic [DATA_W-1:0]      reply_data;
   logic [1:0]             bk_v, bk_we, bk_rm;
   logic [1:0][DATA_W-1:0] bk_data;
   logic [1:0]             bk_in_v, bk_in_rm;

   assign unused_addr_bits = ^req_addr;

   for (genvar c = 0; c < NCL; c++) begin : g_decode
      assign addr_msb[c] = req_addr[c][ADDR_W-1];
      assign req_idx[c]  = req_addr[c][IDX_W-1:0];
      assign remote[c]   = (home[c] != 1'(c));
      assign local_go[c] = req_valid[c] && !remote[c] && !busy;
      assign stall[c]    = busy || (req_valid[c] && remote[c] && !grant[c]);
   end

   dxr_home_map #(.POP_MASK(POP_MASK)) u_home_map (
      .addr_msb (addr_msb),
      .home     (home)
   );

   dxr_remote_ctl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_remote_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .want          (req_valid & remote),
      .req_we        (req_we),
      .req_home      (home),
      .req_idx       (req_idx),
      .req_wdata     (req_wdata),
      .xbus_inflight (xbus_inflight),
      .rrsp_valid    (bk_v & bk_rm),
      .rrsp_data     (bk_data),
      .grant         (grant),
      .busy          (busy),
      .send_valid    (send_valid),
      .send_bank     (send_bank),
      .send_we       (send_we),
      .send_idx      (send_idx),
      .send_wdata    (send_wdata),
      .reply_valid   (reply_valid),
      .reply_cl      (reply_cl),
      .reply_ack     (reply_ack),
      .reply_data    (reply_data)
   );

   for (genvar c = 0; c < NCL; c++) begin : g_bank
      assign bk_in_rm[c] = send_valid && (send_bank == 1'(c));
      assign bk_in_v[c]  = local_go[c] || bk_in_rm[c];

      if (POP_MASK[c]) begin : g_present
         dxr_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .LAT    ((c == 0) ? LAT0 : LAT1)
         ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (bk_in_v[c]),
            .in_we      (bk_in_rm[c] ? send_we    : req_we[c]),
            .in_remote  (bk_in_rm[c]),
            .in_idx     (bk_in_rm[c] ? send_idx   : req_idx[c]),
            .in_wdata   (bk_in_rm[c] ? send_wdata : req_wdata[c]),
            .out_valid  (bk_v[c]),
            .out_we     (bk_we[c]),
            .out_remote (bk_rm[c]),
            .out_data   (bk_data[c])
         );
      end else begin : g_absent
         assign bk_v[c]    = 1'b0;
         assign bk_we[c]   = 1'b0;
         assign bk_rm[c]   = 1'b0;
         assign bk_data[c] = '0;
      end
   end

   for (genvar c = 0; c < NCL; c++) begin : g_rsp
      logic own_rsp, far_rsp;
      assign own_rsp      = bk_v[c] && !bk_rm[c];
      assign far_rsp      = reply_valid && (reply_cl == 1'(c));
      assign rsp_valid[c] = own_rsp || far_rsp;
      assign rsp_ack[c]   = own_rsp ? bk_we[c]   : (far_rsp && reply_ack);
      assign rsp_data[c]  = own_rsp ? bk_data[c] : (far_rsp ? reply_data : '0);

      // R2: a local answer never lands in the same cycle as a crossing answer
      assert_no_rsp_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !(own_rsp && far_rsp));
   end

   // R7: while a crossing is in progress no request of either cluster reaches a module from the cluster side
   assert_frozen_no_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stall == 2'b11) |-> !(|(bk_in_v & ~bk_in_rm)));
endmodule

// File: tb/dcache_xroute_bench.sv
`timescale 1ns/1ps
module dcache_xroute_bench;
   localparam int AW = 12;
   localparam int DW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        req_valid = '0, req_we = '0;
   logic [1:0][AW-1:0] req_addr = '0;
   logic [1:0][DW-1:0] req_wdata = '0;
   logic [2:0]        inflight = '0;
   logic [1:0]        a_stall, a_rv, a_ack, b_stall, b_rv, b_ack;
   logic [1:0][DW-1:0] a_data, b_data;
   logic [1:0]        s_stall, s_rv, s_ack;
   logic [1:0][DW-1:0] s_data;
   int                sel = 0;
   int                cyc = 0;
   int                checks = 0, errors = 0;
   int                drain_hold = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dcache_xroute #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(16), .LAT0(2), .LAT1(4),
                   .CNT_W(3), .POP_MASK(2'b11)) u_dcache_xroute (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .xbus_inflight(inflight),
      .stall(a_stall), .rsp_valid(a_rv), .rsp_ack(a_ack), .rsp_data(a_data));

   dcache_xroute #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(16), .LAT0(3), .LAT1(1),
                   .CNT_W(3), .POP_MASK(2'b01)) u_dcache_xroute_solo (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .xbus_inflight(inflight),
      .stall(b_stall), .rsp_valid(b_rv), .rsp_ack(b_ack), .rsp_data(b_data));

   always_comb begin
      s_stall = (sel == 1) ? b_stall : a_stall;
      s_rv    = (sel == 1) ? b_rv    : a_rv;
      s_ack   = (sel == 1) ? b_ack   : a_ack;
      s_data  = (sel == 1) ? b_data  : a_data;
   end

   // holds the bus busy for a number of cycles counted from the issue cycle
   initial forever begin
      @(negedge clk);
      #0.2;
      if (drain_hold > 0) begin
         drain_hold--;
         if (drain_hold == 0) inflight = '0;
      end
   end

   function automatic logic [AW-1:0] mk(input bit space, input int idx);
      return {space, 7'd0, 4'(idx)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      req_valid = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic access(input int c, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input int hold,
                         output int lat, output int bst,
                         output logic [DW-1:0] rd, output logic ack,
                         output logic stall_at);
      int t0, n;
      @(negedge clk);
      req_valid[c] = 1'b1; req_we[c] = we; req_addr[c] = a; req_wdata[c] = wd;
      if (hold > 0) begin inflight = 3'd2; drain_hold = hold; end
      #0.5;
      n = 0;
      while (s_stall[c] && n < 100) begin @(negedge clk); #0.5; n++; end
      t0 = cyc;
      @(negedge clk);
      req_valid[c] = 1'b0;
      #0.5;
      bst = 0; n = 0;
      while (!s_rv[c] && n < 100) begin
         if (s_stall == 2'b11) bst++;
         @(negedge clk); #0.5; n++;
      end
      lat = cyc - t0; rd = s_data[c]; ack = s_ack[c]; stall_at = s_stall[c];
   endtask

   task automatic t_reset();
      int lat, bst; logic [DW-1:0] rd; logic ack, sa;
      @(negedge clk); #0.5;
      chk(a_stall == 2'b00, "R10 stall after reset", 32'(a_stall), 0);
      chk(a_rv == 2'b00, "R10 rsp_valid after reset", 32'(a_rv), 0);
      access(0, 0, mk(0, 3), 0, 0, lat, bst, rd, ack, sa);
      chk(rd == 0, "R10 word zero after reset", rd, 0);
      chk(lat == 2, "R2 local load latency module 0", 32'(lat), 2);
   endtask

   task automatic t_local();
      int lat, bst; logic [DW-1:0] rd; logic ack, sa;
      access(0, 1, mk(0, 5), 32'hA5A5_0001, 0, lat, bst, rd, ack, sa);
      chk(ack == 1'b1 && rd == 0, "R3 local store ack, zero data", {31'd0, ack}, 1);
      chk(lat == 2 && bst == 0, "R2 local store latency, no stall", 32'(lat), 2);
      access(1, 1, mk(1, 5), 32'hBEEF_0005, 0, lat, bst, rd, ack, sa);
      chk(lat == 4 && ack == 1'b1, "R2 local store latency module 1", 32'(lat), 4);
      access(0, 0, mk(0, 5), 0, 0, lat, bst, rd, ack, sa);
      chk(rd == 32'hA5A5_0001 && ack == 1'b0, "R1 R3 space 0 read back", rd, 32'hA5A5_0001);
      access(1, 0, mk(1, 5), 0, 0, lat, bst, rd, ack, sa);
      chk(rd == 32'hBEEF_0005, "R1 space 1 holds separate word", rd, 32'hBEEF_0005);
      chk(lat == 4 && bst == 0, "R2 local load latency module 1", 32'(lat), 4);
   endtask

   task automatic t_remote_load();
      int lat, bst; logic [DW-1:0] rd; logic ack, sa;
      access(0, 0, mk(1, 5), 0, 0, lat, bst, rd, ack, sa);
      chk(rd == 32'hBEEF_0005 && ack == 1'b0, "R4 crossing load data", rd, 32'hBEEF_0005);
      chk(lat == 7, "R4 crossing load latency", 32'(lat), 7);
      chk(bst == 6, "R4 both clusters frozen", 32'(bst), 6);
      chk(sa == 1'b0, "R4 stall low in answer cycle", {31'd0, sa}, 0);
   endtask

   task automatic t_remote_store();
      int lat, bst; logic [DW-1:0] rd; logic ack, sa;
      access(1, 1, mk(0, 9), 32'h1234_5678, 0, lat, bst, rd, ack, sa);
      chk(ack == 1'b1 && lat == 5, "R6 crossing store ack latency", 32'(lat), 5);
      chk(bst == 4 && sa == 1'b0, "R6 stall drops with ack", 32'(bst), 4);
      access(0, 0, mk(0, 9), 0, 0, lat, bst, rd, ack, sa);
      chk(rd == 32'h1234_5678, "R6 owner sees crossing store", rd, 32'h1234_5678);
   endtask

   task automatic t_drain();
      int lat, bst; logic [DW-1:0] rd; logic ack, sa;
      access(1, 0, mk(0, 9), 0, 7, lat, bst, rd, ack, sa);
      chk(rd == 32'h1234_5678, "R5 drained crossing data", rd, 32'h1234_5678);
      chk(lat == 10, "R5 drain delays answer", 32'(lat), 10);
      chk(bst == 9, "R5 drain lengthens freeze", 32'(bst), 9);
   endtask

   task automatic t_tie();
      int t0, t1, n;
      @(negedge clk);
      req_valid = 2'b11; req_we = 2'b00;
      req_addr[0] = mk(1, 5); req_addr[1] = mk(0, 9);
      #0.5;
      chk(s_stall == 2'b01, "R8 tie: cluster 0 held, cluster 1 taken", 32'(s_stall), 1);
      t0 = cyc;
      @(negedge clk); req_valid[1] = 1'b0; #0.5;
      n = 0;
      while (!s_rv[1] && n < 100) begin @(negedge clk); #0.5; n++; end
      chk(cyc - t0 == 5, "R8 cluster 1 answer latency", 32'(cyc - t0), 5);
      chk(s_data[1] == 32'h1234_5678, "R8 cluster 1 data", s_data[1], 32'h1234_5678);
      chk(s_stall[0] == 1'b1, "R7 waiting crossing held in answer cycle", {31'd0, s_stall[0]}, 1);
      n = 0;
      while (s_stall[0] && n < 100) begin @(negedge clk); #0.5; n++; end
      t1 = cyc;
      chk(t1 - t0 == 6, "R8 cluster 0 accepted after cluster 1", 32'(t1 - t0), 6);
      @(negedge clk); req_valid[0] = 1'b0; #0.5;
      n = 0;
      while (!s_rv[0] && n < 100) begin @(negedge clk); #0.5; n++; end
      chk(cyc - t1 == 7, "R8 cluster 0 answer latency", 32'(cyc - t1), 7);
      chk(s_data[0] == 32'hBEEF_0005, "R8 cluster 0 data", s_data[0], 32'hBEEF_0005);
   endtask

   task automatic t_busy_block();
      int n;
      // cluster 1 crosses; cluster 0 then asks locally during the freeze
      @(negedge clk);
      req_valid[1] = 1'b1; req_we[1] = 1'b0; req_addr[1] = mk(0, 9);
      @(negedge clk);
      req_valid[1] = 1'b0;
      req_valid[0] = 1'b1; req_we[0] = 1'b0; req_addr[0] = mk(0, 5);
      #0.5;
      chk(s_stall[0] == 1'b1, "R7 local request held during crossing", {31'd0, s_stall[0]}, 1);
      n = 0;
      while (s_stall[0] && n < 100) begin @(negedge clk); #0.5; n++; end
      @(negedge clk); req_valid[0] = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_solo();
      int lat, bst; logic [DW-1:0] rd; logic ack, sa;
      sel = 1;
      do_reset();
      access(0, 1, mk(1, 7), 32'h0BAD_CAFE, 0, lat, bst, rd, ack, sa);
      chk(lat == 3 && bst == 0, "R9 cluster 0 local for space 1", 32'(lat), 3);
      access(1, 0, mk(0, 7), 0, 0, lat, bst, rd, ack, sa);
      chk(rd == 32'h0BAD_CAFE, "R9 single module shared by both spaces", rd, 32'h0BAD_CAFE);
      chk(lat == 6, "R9 cluster 1 always crosses", 32'(lat), 6);
      access(1, 1, mk(1, 2), 32'h55, 0, lat, bst, rd, ack, sa);
      chk(lat == 6 && ack == 1'b1, "R9 cluster 1 store crosses", 32'(lat), 6);
      access(0, 0, mk(0, 2), 0, 0, lat, bst, rd, ack, sa);
      chk(rd == 32'h55 && lat == 3, "R9 cluster 0 reads it in space 0", rd, 32'h55);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_local();
      t_remote_load();
      t_remote_store();
      t_drain();
      t_tie();
      t_busy_block();
      t_solo();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule